// File: doc/BRIEF.md
# Dual-Mode System Clock Divider Control

This block turns a fast base clock into clock-enable strobes for two groups of logic: the bus master and the rest of the chip. It holds one byte-wide control register. The register has a mode bit and a 3-bit ratio code. When the mode bit is clear, only the bus-master enable is slowed and the chip-wide enable pulses on every cycle. When the mode bit is set, one divided enable drives the whole chip, and the bus master and the output-clock enable follow it. The block divides with enables, not with derived clocks.

A single free-running prescaler times every strobe. A strobe is a one-cycle pulse that fires when the low k bits of the prescaler are all ones, for a ratio of 2^k. A new ratio is adopted only when a strobe of the old ratio fires, so no pulse is ever cut short or repeated. Software must not change the mode bit and the ratio code in the same write. If a write does change both, the block applies the mode bit, keeps the old code, and raises a sticky error flag.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and `seq_err` is 0. Until the first write, `bm_en`, `chip_en` and `clkout_en` are 1 on every cycle.
- R2: `rd_data` always shows the mode bit at bit 5 and the ratio code at bits 2..0. Bits 7, 6, 4 and 3 read 0, and writing ones to them has no effect.
- R3: With the mode bit at 0, ratio codes 0 to 5 divide `bm_en` by 1, 2, 4, 8, 16 and 32, and `chip_en` pulses on every cycle once it settles.
- R4: With the mode bit at 1, ratio codes 0 to 3 divide `chip_en` by 1, 2, 4 and 8. `clkout_en` equals `chip_en`, and `bm_en` equals `chip_en` once the bus-master divider settles to full speed.
- R5: Codes that have no ratio in the current mode run at full speed: 6 and 7 with the mode bit at 0, and 4 to 7 with the mode bit at 1.
- R6: A write whose bit 5 differs from the stored mode and whose bits 2..0 differ from the stored code updates the mode and leaves the code unchanged.
- R7: `seq_err` is set by a write of the kind in R6 and by nothing else. It stays at 1 until reset.
- R8: A divider with active exponent k pulses for exactly the cycles in which the low k bits of the 5-bit prescaler are all ones. The prescaler is 0 in the first cycle after reset and counts up by one every cycle, wrapping at 32.
- R9: A divider adopts the exponent given by the current register contents only in a cycle where it pulses. Until then it keeps its old exponent, so a ratio can change while the clocks run.
- R10: `bm_en` is never 1 while `chip_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 5 is the mode, bits 2..0 are the ratio code |
| rd_data | output | 8 | Control register readback |
| bm_en | output | 1 | Bus-master clock enable |
| chip_en | output | 1 | Chip-wide clock enable |
| clkout_en | output | 1 | Output-clock pin enable |
| seq_err | output | 1 | Sticky flag for a write that breaks the ordering rule |

## Verification
The bench builds the block with its default parameters: a 5-bit prescaler, a bus-master limit of exponent 5 and a chip-wide limit of exponent 3. This makes every legal code in both modes reachable, including the slowest bus-master ratio of /32, which spans the full prescaler wrap. Random writes arrive at arbitrary prescaler phases, so ratio changes land both in the middle of a divide period and on its boundary. Writes that keep to the ordering rule are mixed with writes that break it, which also tests the cases where the mode changes while a divider is still waiting for its boundary.

// File: rtl/clkdiv_pkg.sv
// Shared constants and types for the clock divider control block.
// Assumes a byte-wide register with the mode bit and the ratio code at
// fixed positions that software depends on.
package clkdiv_pkg;
    localparam int REG_W    = 8;
    localparam int MODE_BIT = 5;
    localparam int SEL_W    = 3;

    typedef enum logic {
        MODE_BM_ONLY = 1'b0,
        MODE_CHIP    = 1'b1
    } div_mode_e;
endpackage

// File: rtl/clkdiv_regs.sv
// Control register with the write-ordering rule.
// Holds the mode bit and the ratio code. A write that changes both at
// once updates only the mode and sets a sticky error flag. Bits with no
// function are never stored and read back as zero.
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output div_mode_e        mode,
    output logic [SEL_W-1:0] sel,
    output logic             seq_err,
    output logic [REG_W-1:0] rd_data
);
    logic conflict;

    // Detect a write that changes the mode and the code together.
    always_comb begin
        conflict = (wr_data[MODE_BIT] != logic'(mode)) &&
                   (wr_data[SEL_W-1:0] != sel);
    end

    // Register update with the ordering rule applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_BM_ONLY;
            sel     <= '0;
            seq_err <= 1'b0;
        end else if (wr_en) begin
            mode <= div_mode_e'(wr_data[MODE_BIT]);
            if (!conflict) begin
                sel <= wr_data[SEL_W-1:0];
            end else begin
                seq_err <= 1'b1;
            end
        end
    end

    // Readback: only the mode bit and the code are stored.
    always_comb begin
        rd_data                 = '0;
        rd_data[MODE_BIT]       = logic'(mode);
        rd_data[SEL_W-1:0]      = sel;
    end

    // R6: a write that changes both fields must leave the code unchanged
    p_order_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && conflict) |=> (sel == $past(sel)) && seq_err);

    // R7: the error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R7: the flag rises only after a write that breaks the ordering rule
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(wr_en && conflict));
endmodule

// File: rtl/clkdiv_prescaler.sv
// Free-running prescaler shared by all dividers.
// Clears in reset and then counts up by one every base-clock cycle,
// wrapping naturally. All strobes are decoded from this one count so
// they stay phase-aligned with each other.
module clkdiv_prescaler #(
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PRESC_W-1:0] count
);
    // Increment every cycle, clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    // R8: the prescaler advances by exactly one per cycle
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == PRESC_W'($past(count) + 1'b1)));
endmodule

// File: rtl/clkdiv_strobe.sv
// One divider channel.
// Produces a single-cycle strobe whenever the low act_k bits of the
// shared prescaler are all ones. The requested exponent is adopted only
// in a strobe cycle, so a period in progress is never cut short.
// Assumes tgt_k never exceeds PRESC_W.
module clkdiv_strobe #(
    parameter int PRESC_W = 5,
    parameter int K_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] count,
    input  logic [K_W-1:0]     tgt_k,
    output logic               strobe
);
    logic [K_W-1:0]     act_k;
    logic [PRESC_W-1:0] low_mask;

    // Mask of the prescaler bits that take part in this ratio.
    always_comb begin
        low_mask = ~({PRESC_W{1'b1}} << act_k);
        strobe   = &(count | ~low_mask);
    end

    // Adopt a new exponent only at the end of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_k <= '0;
        end else if (strobe) begin
            act_k <= tgt_k;
        end
    end

    // R9: the exponent holds between strobes
    p_switch_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(act_k));

    // R8: a divided strobe is one cycle wide
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && act_k != '0 && tgt_k != '0) |=> !strobe);
endmodule

// File: rtl/clkdiv_ctrl.sv
// Top level of the dual-mode clock divider control.
// Decodes the mode and the ratio code into one target exponent per
// channel. Channel 0 times the chip-wide enable and channel 1 the
// bus master. The bus-master enable is the AND of both strobes, so it
// runs at the slower of the two ratios and never pulses unless the chip
// enable pulses too. Codes with no ratio in a mode mean full speed.
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int PRESC_W    = 5,
    parameter int BM_MAX_K   = 5,
    parameter int CHIP_MAX_K = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       bm_en,
    output logic       chip_en,
    output logic       clkout_en,
    output logic       seq_err
);
    localparam int K_W    = $clog2(PRESC_W + 1);
    localparam int N_CHAN = 2;
    localparam int CH_CHIP = 0;
    localparam int CH_BM   = 1;

    div_mode_e          mode;
    logic [SEL_W-1:0]   sel;
    logic [PRESC_W-1:0] count;
    logic [K_W-1:0]     tgt_k [N_CHAN];
    logic [N_CHAN-1:0]  stb;

    clkdiv_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode    (mode),
        .sel     (sel),
        .seq_err (seq_err),
        .rd_data (rd_data)
    );

    clkdiv_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    // Map the code to an exponent per channel; codes beyond a limit mean full speed.
    always_comb begin
        tgt_k[CH_CHIP] = '0;
        tgt_k[CH_BM]   = '0;
        if (mode == MODE_CHIP) begin
            if (int'(sel) <= CHIP_MAX_K) tgt_k[CH_CHIP] = K_W'(sel);
        end else begin
            if (int'(sel) <= BM_MAX_K) tgt_k[CH_BM] = K_W'(sel);
        end
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        clkdiv_strobe #(.PRESC_W(PRESC_W), .K_W(K_W)) u_stb (
            .clk    (clk),
            .rst_n  (rst_n),
            .count  (count),
            .tgt_k  (tgt_k[g]),
            .strobe (stb[g])
        );
    end

    // Drive the enables from the channel strobes.
    always_comb begin
        chip_en   = stb[CH_CHIP];
        clkout_en = stb[CH_CHIP];
        bm_en     = stb[CH_CHIP] & stb[CH_BM];
    end

    // R10: the bus master never runs without the chip clock
    p_bm_within_chip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bm_en |-> chip_en);

    // R3: in the bus-master-only mode, after a chip strobe at full target the next cycle strobes too
    p_chip_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BM_ONLY && chip_en) |=> chip_en);
endmodule

// File: tb/sim_clkdiv_ctrl.sv
`timescale 1ns/1ps
module sim_clkdiv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       bm_en, chip_en, clkout_en, seq_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic       m_mode = 1'b0;
    logic [2:0] m_sel = '0;
    logic       m_err = 1'b0;
    logic [4:0] m_cnt = '0;
    int         m_kbm = 0;
    int         m_kchip = 0;

    always #4 clk = ~clk;

    clkdiv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bm_en(bm_en), .chip_en(chip_en),
        .clkout_en(clkout_en), .seq_err(seq_err)
    );

    function automatic logic pulse(input logic [4:0] cnt, input int k);
        logic [4:0] m;
        m = 5'((32'd1 << k) - 1);
        return (cnt & m) == m;
    endfunction

    function automatic int want_bm(input logic md, input logic [2:0] s);
        return (md == 1'b0 && s <= 3'd5) ? int'(s) : 0;
    endfunction

    function automatic int want_chip(input logic md, input logic [2:0] s);
        return (md == 1'b1 && s <= 3'd3) ? int'(s) : 0;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Check outputs against the model, apply inputs, then advance one edge.
    task automatic step(input logic we, input logic [7:0] d);
        logic e_chip, e_bm, conflict;
        logic       n_mode, n_err;
        logic [2:0] n_sel;
        int         n_kbm, n_kchip;
        e_chip = pulse(m_cnt, m_kchip);
        e_bm   = e_chip & pulse(m_cnt, m_kbm);
        chk("R3 R4 R5 R8 R9 bm_en", {7'd0, bm_en}, {7'd0, e_bm});
        chk("R3 R4 R8 R9 chip_en", {7'd0, chip_en}, {7'd0, e_chip});
        chk("R4 clkout_en", {7'd0, clkout_en}, {7'd0, e_chip});
        chk("R2 R6 rd_data", rd_data, {2'b00, m_mode, 2'b00, m_sel});
        chk("R7 seq_err", {7'd0, seq_err}, {7'd0, m_err});
        chk("R10 bm without chip", {7'd0, bm_en & ~chip_en}, 8'd0);
        wr_en = we;
        wr_data = d;
        n_mode = m_mode; n_sel = m_sel; n_err = m_err;
        n_kbm = pulse(m_cnt, m_kbm) ? want_bm(m_mode, m_sel) : m_kbm;
        n_kchip = pulse(m_cnt, m_kchip) ? want_chip(m_mode, m_sel) : m_kchip;
        if (we) begin
            conflict = (d[5] != m_mode) && (d[2:0] != m_sel);
            n_mode = d[5];
            if (conflict) n_err = 1'b1;
            else n_sel = d[2:0];
        end
        @(posedge clk);
        m_mode = n_mode; m_sel = n_sel; m_err = n_err;
        m_kbm = n_kbm; m_kchip = n_kchip; m_cnt = m_cnt + 5'd1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, full speed everywhere
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk("R1 enables after reset", {5'd0, bm_en, chip_en, clkout_en}, 8'h07);
        idle(6);
        // R2: reserved bits written as ones, code 3 in mode 0 (R3 /8)
        step(1'b1, 8'hDB);
        chk("R2 reserved bits read zero", rd_data, 8'h03);
        idle(40);
        // R3: slowest bus-master ratio /32
        step(1'b1, 8'h05);
        idle(80);
        // R6 R7: mode and code changed together, code kept, flag set
        step(1'b1, 8'h22);
        chk("R6 code kept", rd_data, 8'h25);
        chk("R7 flag set", {7'd0, seq_err}, 8'd1);
        idle(40);
        // R4: chip-wide /8 after legal code write
        step(1'b1, 8'h23);
        idle(40);
        // R5: unlisted code in mode 1
        step(1'b1, 8'h27);
        idle(20);
        // R5: unlisted code in mode 0 (mode-only change is legal)
        step(1'b1, 8'h07);
        idle(20);
        // Random mix of legal and illegal writes at arbitrary phases
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [7:0] d;
            r = int'($urandom % 16);
            if (r == 0) begin
                d = 8'($urandom);
                step(1'b1, d);
            end else if (r == 1) begin
                d = {2'($urandom), m_mode, 2'($urandom), 3'($urandom)};
                step(1'b1, d);
            end else if (r == 2) begin
                d = {2'b00, ~m_mode, 2'b00, m_sel};
                step(1'b1, d);
            end else begin
                step(1'b0, 8'h00);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule